// File: doc/BRIEF.md
# Extended Capability Chain Walker

This block searches the extended configuration area of a PCIe function for a capability with a given 16-bit identifier. It begins at byte offset 0x100 and reads one dword header at a time through a synchronous read port whose data arrives one cycle after the request. From each header it takes the identifier and the next-entry pointer, and it follows the chain until one of these happens: a match, a zero pointer, an illegal pointer, or too many visits.

The result gives four things: whether the identifier was found, the matching offset, the offset of the entry visited just before the final one, and an error flag. An append operation walks the chain to its last entry using a key that can never match. It then rewrites that entry's header so that the pointer refers to a new offset, and it leaves the identifier and version bits unchanged. Software or a configuration-space builder uses this to link a freshly placed capability onto the end of the chain.

Top module: `xcap_chain_walker`

## Requirements
- R1: While reset is high and after it falls, busy, done, found, err, rd_en and wr_en are all 0, and cap_off and prev_off are 0.
- R2: If the dword at 0x100 is all zero, the list is empty. A search ends after that single read with found=0, err=0, cap_off=0 and prev_off=0.
- R3: A header holds the identifier in bits 15:0, a version in bits 19:16 that the walker ignores, and the next offset in bits 31:20. The two low bits of the next offset are ignored, so the pointer is always forced to dword alignment.
- R4: When the header identifier equals search_id, done comes with found=1, cap_off set to that entry's offset, and prev_off set to the entry visited before it (0 if the match is at 0x100).
- R5: When a non-matching entry has a zero next pointer, done comes with found=0, cap_off=0, err=0, and prev_off set to the offset of that last entry.
- R6: search_id is 17 bits wide. When bit 16 is set the key never matches, so the search returns the tail of the list as in R5.
- R7: A next pointer below 0x100 or above 0xFF8 stops the walk with err=1 and found=0. Reads are only ever issued to dword-aligned offsets in the range 0x100 to 0xFF8.
- R8: A walk that would need more than MAX_VISITS header reads stops with err=1 after MAX_VISITS reads. A match exactly on read number MAX_VISITS still succeeds.
- R9: With op_append=1, the walker finds the tail. In the cycle that evaluates the tail, it writes that tail's header with bits 31:20 replaced by new_off and bits 19:0 kept. done then reports err=0, found=0, cap_off=new_off and prev_off=tail offset.
- R10: An append is rejected with err=1 and no write in two cases. If new_off is not dword aligned, is at or below 0x100, or is above 0xFF8, done rises on the edge that accepts start and no read is made. If the list is empty, done rises after the single read.
- R11: done is a one-cycle pulse. For a walk of N reads, it is high after the edge that comes 2N edges after the edge accepting start. Two reads are never requested on consecutive cycles, and the result outputs hold their values until the next accepted start.
- R12: A start pulse while busy=1 is ignored, and the walk in progress finishes with its original key.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation when idle |
| op_append | input | 1 | 1 = append new_off at tail, 0 = search |
| search_id | input | 17 | Capability key; bit 16 set never matches |
| new_off | input | 12 | Offset to link in on append |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | Key matched |
| err | output | 1 | Illegal pointer, visit limit or bad append |
| cap_off | output | 12 | Matching offset, or new_off on append |
| prev_off | output | 12 | Offset of entry visited before the final one |
| rd_en | output | 1 | Header read request |
| rd_addr | output | 12 | Byte offset of requested header |
| rd_data | input | 32 | Header dword, valid the cycle after rd_en |
| wr_en | output | 1 | Tail header write strobe |
| wr_addr | output | 12 | Byte offset of tail header |
| wr_data | output | 32 | Rewritten tail header |

## Verification
The assertions assume that rd_data holds the addressed dword exactly one cycle after rd_en, and that a write takes effect on the edge where wr_en is high. The bench's memory model provides both. They also assume that start is a clean synchronous pulse. The bench drives start only at the falling edge and holds it for one cycle. Its header images are built by a function that uses the stated bit layout. It places low bits into one pointer and version values into others, so the ignored fields are exercised without ever leaving the walker with an ambiguous header.

// File: rtl/xcw_pkg.sv
package xcw_pkg;

    localparam int XCW_AW = 12;
    localparam logic [XCW_AW-1:0] XCW_BASE = 12'h100;
    localparam logic [XCW_AW-1:0] XCW_TOP  = 12'hFF8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_EVAL
    } xcw_state_e;

    typedef struct packed {
        logic [XCW_AW-1:0] link;
        logic [3:0]        ver;
        logic [15:0]       id;
    } xcw_hdr_t;

    function automatic logic xcw_off_legal(logic [XCW_AW-1:0] o);
        return (o >= XCW_BASE) && (o <= XCW_TOP) && (o[1:0] == 2'b00);
    endfunction

endpackage

// File: rtl/xcw_hdr_check.sv
module xcw_hdr_check
    import xcw_pkg::*;
(
    input  logic [31:0]       word,
    input  logic [16:0]       key,
    output logic              hit,
    output logic [XCW_AW-1:0] link_off,
    output logic              link_zero,
    output logic              link_bad
);
    xcw_hdr_t hdr;

    always_comb begin
        hdr       = xcw_hdr_t'(word);
        link_off  = {hdr.link[XCW_AW-1:2], 2'b00};
        hit       = !key[16] && (hdr.id == key[15:0]);
        link_zero = (link_off == '0);
        link_bad  = !link_zero && !xcw_off_legal(link_off);
    end
endmodule

// File: rtl/xcw_visit_limit.sv
module xcw_visit_limit #(
    parameter int MAX_VISITS = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic at_last
);
    localparam int CW = $clog2(MAX_VISITS) + 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (inc)   cnt <= cnt + 1'b1;
    end

    assign at_last = (cnt == CW'(MAX_VISITS - 1));

    a_r8_no_overrun: assert property (@(posedge clk) disable iff (rst)
        inc |-> (cnt < CW'(MAX_VISITS)));
endmodule

// File: rtl/xcap_chain_walker.sv
module xcap_chain_walker
    import xcw_pkg::*;
#(
    parameter int MAX_VISITS = 1024
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        op_append,
    input  logic [16:0] search_id,
    input  logic [11:0] new_off,
    output logic        busy,
    output logic        done,
    output logic        found,
    output logic        err,
    output logic [11:0] cap_off,
    output logic [11:0] prev_off,
    output logic        rd_en,
    output logic [11:0] rd_addr,
    input  logic [31:0] rd_data,
    output logic        wr_en,
    output logic [11:0] wr_addr,
    output logic [31:0] wr_data
);
    xcw_state_e        state;
    logic [XCW_AW-1:0] cur, prv, noff;
    logic [16:0]       key;
    logic              app;

    logic              hit, link_zero, link_bad, at_last;
    logic [XCW_AW-1:0] link_off;
    logic              accept, bad_arg, empty, tail;

    xcw_hdr_check u_chk (
        .word      (rd_data),
        .key       (key),
        .hit       (hit),
        .link_off  (link_off),
        .link_zero (link_zero),
        .link_bad  (link_bad)
    );

    xcw_visit_limit #(.MAX_VISITS(MAX_VISITS)) u_lim (
        .clk     (clk),
        .rst     (rst),
        .clr     (accept),
        .inc     (state == ST_EVAL),
        .at_last (at_last)
    );

    assign accept  = (state == ST_IDLE) && start;
    assign bad_arg = op_append && (!xcw_off_legal(new_off) || new_off == XCW_BASE);
    assign empty   = (prv == '0) && (rd_data == 32'h0);
    assign tail    = !empty && !hit && link_zero;

    assign busy    = (state != ST_IDLE);
    assign rd_en   = (state == ST_READ);
    assign rd_addr = cur;
    assign wr_en   = (state == ST_EVAL) && app && tail;
    assign wr_addr = cur;
    assign wr_data = {noff, rd_data[19:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cur      <= XCW_BASE;
            prv      <= '0;
            noff     <= '0;
            key      <= '0;
            app      <= 1'b0;
            done     <= 1'b0;
            found    <= 1'b0;
            err      <= 1'b0;
            cap_off  <= '0;
            prev_off <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: if (start) begin
                    key      <= op_append ? 17'h10000 : search_id;
                    app      <= op_append;
                    noff     <= new_off;
                    cur      <= XCW_BASE;
                    prv      <= '0;
                    found    <= 1'b0;
                    cap_off  <= '0;
                    prev_off <= '0;
                    err      <= bad_arg;
                    if (bad_arg) done  <= 1'b1;
                    else         state <= ST_READ;
                end
                ST_READ: state <= ST_EVAL;
                ST_EVAL: begin
                    if (empty) begin
                        err   <= app;
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end else if (hit) begin
                        found    <= 1'b1;
                        cap_off  <= cur;
                        prev_off <= prv;
                        done     <= 1'b1;
                        state    <= ST_IDLE;
                    end else if (link_zero) begin
                        cap_off  <= app ? noff : '0;
                        prev_off <= cur;
                        done     <= 1'b1;
                        state    <= ST_IDLE;
                    end else if (link_bad || at_last) begin
                        err      <= 1'b1;
                        prev_off <= cur;
                        done     <= 1'b1;
                        state    <= ST_IDLE;
                    end else begin
                        prv   <= cur;
                        cur   <= link_off;
                        state <= ST_READ;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    a_r11_read_spacing: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> !rd_en);
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r7_read_legal: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (rd_addr >= XCW_BASE && rd_addr <= XCW_TOP && rd_addr[1:0] == 2'b00));
    a_r9_write_completes: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (done && !err && !found && prev_off == $past(wr_addr)));
    a_r4_found_clean: assert property (@(posedge clk) disable iff (rst)
        (done && found) |-> (!err && cap_off >= XCW_BASE));
    a_r12_busy_until_done: assert property (@(posedge clk) disable iff (rst)
        (busy && !$past(busy) && !done) |=> (busy || done));
endmodule

// File: tb/xcap_chain_walker_test.sv
`timescale 1ns/1ps
module xcap_chain_walker_test;
    localparam int LIM = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        op_append = 1'b0;
    logic [16:0] search_id = '0;
    logic [11:0] new_off = '0;
    logic        busy, done, found, err;
    logic [11:0] cap_off, prev_off;
    logic        rd_en, wr_en;
    logic [11:0] rd_addr, wr_addr;
    logic [31:0] rd_data, wr_data;

    logic [31:0] mem [0:1023];
    logic        tb_we = 1'b0, tb_clr = 1'b0;
    logic [11:0] tb_wa = '0;
    logic [31:0] tb_wd = '0;
    int          wr_cnt = 0;
    int          checks = 0, failures = 0;

    always #10 clk = ~clk;

    xcap_chain_walker #(.MAX_VISITS(LIM)) uut (
        .clk(clk), .rst(rst), .start(start), .op_append(op_append),
        .search_id(search_id), .new_off(new_off), .busy(busy), .done(done),
        .found(found), .err(err), .cap_off(cap_off), .prev_off(prev_off),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    always @(posedge clk) begin
        if (rd_en) rd_data <= mem[rd_addr[11:2]];
        if (tb_clr) begin
            for (int i = 0; i < 1024; i++) mem[i] <= 32'h0;
        end else if (wr_en) begin
            mem[wr_addr[11:2]] <= wr_data;
            wr_cnt <= wr_cnt + 1;
        end else if (tb_we) begin
            mem[tb_wa[11:2]] <= tb_wd;
        end
    end

    function automatic logic [31:0] hdr(logic [11:0] nx, logic [3:0] v, logic [15:0] id);
        return {nx, v, id};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic poke(logic [11:0] a, logic [31:0] d);
        @(negedge clk); tb_we = 1'b1; tb_wa = a; tb_wd = d;
        @(negedge clk); tb_we = 1'b0;
    endtask

    task automatic wipe();
        @(negedge clk); tb_clr = 1'b1;
        @(negedge clk); tb_clr = 1'b0;
    endtask

    task automatic base_chain();
        wipe();
        poke(12'h100, hdr(12'h140, 4'h1, 16'h0001));
        poke(12'h140, hdr(12'h1A3, 4'h2, 16'h000E));
        poke(12'h1A0, hdr(12'h000, 4'hF, 16'h0003));
    endtask

    // edges counted include the accepting edge; done seen after edge 2N+1
    task automatic run(input logic app, input logic [16:0] id, input logic [11:0] no,
                       output int cyc);
        @(negedge clk);
        start = 1'b1; op_append = app; search_id = id; new_off = no;
        cyc = 0;
        for (int k = 0; k < 4000; k++) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            start = 1'b0;
            if (done) break;
        end
    endtask

    typedef struct packed {
        logic [16:0] id;
        logic        fnd;
        logic [11:0] off;
        logic [11:0] prv;
        logic [4:0]  n;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{17'h00001, 1'b1, 12'h100, 12'h000, 5'd1},
        '{17'h0000E, 1'b1, 12'h140, 12'h100, 5'd2},
        '{17'h00003, 1'b1, 12'h1A0, 12'h140, 5'd3},
        '{17'h00005, 1'b0, 12'h000, 12'h1A0, 5'd3},
        '{17'h10001, 1'b0, 12'h000, 12'h1A0, 5'd3}
    };

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int cyc;
        int w0;
        logic [31:0] snap;

        repeat (3) @(negedge clk);
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 rd_en", rd_en, 0);
        chk("R1 wr_en", wr_en, 0);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk("R1 outs", {found, err, cap_off, prev_off}, 0);

        base_chain();
        // R3 R4 R5 R6 table walk
        foreach (VECS[i]) begin
            run(1'b0, VECS[i].id, 12'h0, cyc);
            chk("R4/R5/R6 found", found, VECS[i].fnd);
            chk("R4/R5/R6 cap_off", cap_off, VECS[i].off);
            chk("R4/R5/R6 prev_off", prev_off, VECS[i].prv);
            chk("R4/R5/R6 err", err, 0);
            chk("R11 latency", cyc, 2 * VECS[i].n + 1);
        end

        // R11 pulse and hold
        @(negedge clk);
        chk("R11 done pulse", done, 0);
        repeat (3) @(negedge clk);
        chk("R11 hold", {found, cap_off, prev_off}, {1'b0, 12'h000, 12'h1A0});

        // R12 start while busy ignored
        @(negedge clk); start = 1'b1; search_id = 17'h00003; op_append = 1'b0;
        @(negedge clk); start = 1'b0;
        @(negedge clk); start = 1'b1; search_id = 17'h00001;
        @(negedge clk); start = 1'b0;
        for (int k = 0; k < 100 && !done; k++) @(negedge clk);
        chk("R12 cap_off", cap_off, 12'h1A0);
        chk("R12 found", found, 1);

        // R9 append
        w0 = wr_cnt;
        run(1'b1, 17'h0, 12'h200, cyc);
        chk("R9 err", err, 0);
        chk("R9 cap_off", cap_off, 12'h200);
        chk("R9 prev_off", prev_off, 12'h1A0);
        chk("R9 latency", cyc, 7);
        @(negedge clk);
        chk("R9 write count", wr_cnt - w0, 1);
        chk("R9 tail header", mem[12'h1A0 >> 2], 32'h200F0003);
        poke(12'h200, hdr(12'h000, 4'h1, 16'h0009));
        run(1'b0, 17'h00009, 12'h0, cyc);
        chk("R9 linked", {found, cap_off, prev_off}, {1'b1, 12'h200, 12'h1A0});

        // R10 bad arguments
        snap = mem[12'h200 >> 2];
        w0 = wr_cnt;
        run(1'b1, 17'h0, 12'h202, cyc);
        chk("R10 misaligned err", err, 1);
        chk("R10 misaligned latency", cyc, 1);
        run(1'b1, 17'h0, 12'h0F0, cyc);
        chk("R10 low err", err, 1);
        run(1'b1, 17'h0, 12'h100, cyc);
        chk("R10 base err", err, 1);
        @(negedge clk);
        chk("R10 no write", wr_cnt - w0, 0);
        chk("R10 tail kept", mem[12'h200 >> 2], snap);

        // R2 empty list; R10 append on empty
        wipe();
        run(1'b0, 17'h00000, 12'h0, cyc);
        chk("R2 result", {found, err, cap_off, prev_off}, 0);
        chk("R2 latency", cyc, 3);
        w0 = wr_cnt;
        run(1'b1, 17'h0, 12'h300, cyc);
        chk("R10 empty err", err, 1);
        chk("R10 empty latency", cyc, 3);
        @(negedge clk);
        chk("R10 empty no write", wr_cnt - w0, 0);

        // R7 illegal pointers and top boundary
        poke(12'h100, hdr(12'h080, 4'h0, 16'h0001));
        run(1'b0, 17'h00022, 12'h0, cyc);
        chk("R7 low ptr err", {err, found}, 2'b10);
        chk("R7 low ptr latency", cyc, 3);
        poke(12'h100, hdr(12'hFFC, 4'h0, 16'h0001));
        run(1'b0, 17'h00022, 12'h0, cyc);
        chk("R7 high ptr err", err, 1);
        poke(12'h100, hdr(12'hFF8, 4'h0, 16'h0001));
        poke(12'hFF8, hdr(12'h000, 4'h0, 16'h0022));
        run(1'b0, 17'h00022, 12'h0, cyc);
        chk("R7 top legal", {err, found, cap_off}, {2'b01, 12'hFF8});

        // R8 exact limit and loop
        wipe();
        for (int e = 0; e < LIM; e++)
            poke(12'h100 + 12'(16 * e),
                 hdr((e == LIM - 1) ? 12'h000 : 12'h100 + 12'(16 * (e + 1)), 4'h0,
                     (e == LIM - 1) ? 16'h0077 : 16'h0010));
        run(1'b0, 17'h00077, 12'h0, cyc);
        chk("R8 limit match", {err, found, cap_off, prev_off}, {2'b01, 12'h1F0, 12'h1E0});
        chk("R8 limit latency", cyc, 2 * LIM + 1);
        poke(12'h140, hdr(12'h100, 4'h0, 16'h0010));
        run(1'b0, 17'h00077, 12'h0, cyc);
        chk("R8 loop err", {err, found}, 2'b10);
        chk("R8 loop latency", cyc, 2 * LIM + 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule